// File: doc/BRIEF.md
# Audio Master Clock Generator

This block runs in the master clock domain of an audio converter that acts as clock master. From that clock it derives a frame (left/right) clock at the sample rate and a bit-clock strobe at 64 times the sample rate. A 3-bit rate selector sets a pre-divider of 1, 1.5, 2, 3 or 4, so that several master-clock frequencies can be used. A 2-bit speed selector then sets the frame length after the pre-divider: 256 divided cycles for single speed, 128 for double and 64 for quad. The ratio of bit clock to frame clock is therefore 64 in every legal mode.

The fractional ratios come from a repeating enable pattern in the master clock domain, so the block needs only one clock. The bit clock is delivered as a one-cycle strobe in each bit period. This keeps it usable when it runs at the full master clock rate. The strobe marks the bit-clock falling edge, and the frame clock changes only in strobe cycles.

When either selector changes, the counters restart on that clock edge. Both outputs then stay low for one whole frame before toggling starts again. Reserved selector values hold both outputs idle and raise an error flag.

Top module: `aud_master_clkgen`

## Requirements
- R1: `rate_sel_i` picks the pre-divider: 000 gives ÷1, 001 gives ÷1.5, 010 gives ÷2, 011 gives ÷3 and 100 gives ÷4. The frame period in clock cycles scales by that factor.
- R2: `speed_sel_i` value 00 (single) makes a frame period of 256 pre-divided cycles, 01 (double) makes 128 and 10 (quad) makes 64. The period in clock cycles is that count times the pre-divider.
- R3: Every frame period holds exactly 64 cycles with `bit_stb_o` high, in every legal mode.
- R4: `frame_o` is high for exactly half of each frame period. Low marks the left channel and high marks the right channel.
- R5: Every rising or falling edge of `frame_o` that is not caused by a restart happens in a cycle where `bit_stb_o` is high.
- R6: After either selector changes, both outputs are low from the next cycle onward. They stay low for at least one full frame period of the new mode.
- R7: A reserved selector value (`rate_sel_i` 101 to 111, or `speed_sel_i` 11) sets `cfg_err_o` one cycle later. While `cfg_err_o` is high, both outputs stay low.
- R8: While `rst_ni` is low at a clock edge, `frame_o`, `bit_stb_o` and `cfg_err_o` are all low after that edge.
- R9: With the ÷1.5 pre-divider and quad speed, `bit_stb_o` follows a repeating pattern of two high cycles and one low cycle. Any three consecutive cycles hold exactly two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; every register uses its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| rate_sel_i | input | 3 | Pre-divider selector (÷1, ÷1.5, ÷2, ÷3, ÷4) |
| speed_sel_i | input | 2 | Speed selector (single, double, quad) |
| frame_o | output | 1 | Frame clock: low for left, high for right |
| bit_stb_o | output | 1 | One-cycle strobe per bit period, marks the bit-clock falling edge |
| cfg_err_o | output | 1 | High while a reserved selector value is applied |

## Verification
The bench measures the frame period, the high time and the strobe count for all fifteen legal selector pairs. A wrong fractional pattern or a wrong speed shift shows up there as a wrong period, for example 256 instead of 384. An off-by-one frame counter shows up as 63 or 65 strobes or an uneven duty cycle. The bench also checks that each frame edge lands on a strobe cycle, because a frame clock updated outside the strobe would be skewed against the bit clock. It restarts the block in the middle of a frame and applies reserved codes. A design that kept its old counters would toggle early, and one that ignored reserved values would keep clocking with no error flag. A dense 2-of-3 strobe check at ÷1.5 quad speed catches a fractional divider that drops or doubles pulses.

// File: rtl/aud_clk_pkg.sv
// Package: shared selector encodings and helper functions for the audio
// master clock generator. Assumes a 3-bit rate code and a 2-bit speed code.
package aud_clk_pkg;

    localparam logic [2:0] RATE_DIV1   = 3'b000;
    localparam logic [2:0] RATE_DIV1P5 = 3'b001;
    localparam logic [2:0] RATE_DIV2   = 3'b010;
    localparam logic [2:0] RATE_DIV3   = 3'b011;
    localparam logic [2:0] RATE_DIV4   = 3'b100;

    localparam logic [1:0] SPEED_SINGLE = 2'b00;
    localparam logic [1:0] SPEED_DOUBLE = 2'b01;
    localparam logic [1:0] SPEED_QUAD   = 2'b10;

    // True when the rate code is one of the five defined dividers.
    function automatic logic rate_code_ok(input logic [2:0] code);
        return (code <= RATE_DIV4);
    endfunction

    // True when the speed code is single, double or quad.
    function automatic logic speed_code_ok(input logic [1:0] code);
        return (code != 2'b11);
    endfunction

    // Length, in clock cycles, of the repeating enable pattern for a rate code.
    function automatic logic [2:0] rate_pattern_len(input logic [2:0] code);
        case (code)
            RATE_DIV1:   return 3'd1;
            RATE_DIV1P5: return 3'd3;
            RATE_DIV2:   return 3'd2;
            RATE_DIV3:   return 3'd3;
            RATE_DIV4:   return 3'd4;
            default:     return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/aud_cfg_guard.sv
// Module: aud_cfg_guard
// Registers the selector inputs and raises a synchronous restart whenever
// they change or hold a reserved value. It also produces the error flag.
// Assumes: the selectors are static in the clock domain (already synchronised).
module aud_cfg_guard
    import aud_clk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] rate_sel_i,
    input  logic [1:0] speed_sel_i,
    output logic [2:0] rate_q_o,
    output logic [1:0] speed_q_o,
    output logic       clear_o,
    output logic       cfg_err_o
);

    logic [2:0] rate_q;
    logic [1:0] speed_q;
    logic       err_q;
    logic       held_ok;

    // Capture the selectors every cycle, reset included, so change detection is clean.
    always_ff @(posedge clk_i) begin
        rate_q  <= rate_sel_i;
        speed_q <= speed_sel_i;
    end

    // Error flag: set one cycle after a reserved value is applied.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            err_q <= 1'b0;
        end else begin
            err_q <= !(rate_code_ok(rate_sel_i) && speed_code_ok(speed_sel_i));
        end
    end

    // Restart on any selector change or while a reserved value is held.
    always_comb begin
        held_ok = rate_code_ok(rate_q) && speed_code_ok(speed_q);
        clear_o = (rate_sel_i != rate_q) || (speed_sel_i != speed_q) || !held_ok;
    end

    assign rate_q_o  = rate_q;
    assign speed_q_o = speed_q;
    assign cfg_err_o = err_q;

endmodule

// File: rtl/aud_prediv.sv
// Module: aud_prediv
// Fractional pre-divider. It produces a one-cycle enable pattern that repeats
// over 1 to 4 clock cycles: every cycle for ÷1, two of three cycles for ÷1.5,
// and one per N cycles for ÷2, ÷3 and ÷4.
// Assumes: rate_sel_i is a legal code whenever clear_i is low.
module aud_prediv
    import aud_clk_pkg::*;
#(
    parameter int PHASE_W = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic [2:0] rate_sel_i,
    output logic       tick_o
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_last;

    // Last phase index of the current pattern.
    always_comb begin
        phase_last = PHASE_W'(rate_pattern_len(rate_sel_i) - 3'd1);
    end

    // Phase counter: wraps at the pattern length and restarts on clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            phase_q <= '0;
        end else if (phase_q == phase_last) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Enable decode: 1.5 skips the third phase, integer ratios fire on phase zero.
    always_comb begin
        case (rate_sel_i)
            RATE_DIV1:   tick_o = 1'b1;
            RATE_DIV1P5: tick_o = (phase_q != PHASE_W'(2));
            default:     tick_o = (phase_q == '0);
        endcase
    end

endmodule

// File: rtl/aud_frame_seq.sv
// Module: aud_frame_seq
// Counts pre-divided ticks over one frame. It issues the bit strobe every
// (BASE_TICKS/BITS_PER_FRAME >> speed) ticks and the frame level, which
// changes only on a strobe. The outputs stay low through the first frame
// after clear.
// Assumes: speed_sel_i is legal whenever clear_i is low.
module aud_frame_seq #(
    parameter int BASE_TICKS     = 256,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic       tick_i,
    input  logic [1:0] speed_sel_i,
    output logic       frame_o,
    output logic       bit_stb_o
);

    localparam int POS_W     = $clog2(BASE_TICKS);
    localparam int STEP_BASE = BASE_TICKS / BITS_PER_FRAME;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] last_pos;
    logic [POS_W-1:0] half_pos;
    logic [POS_W-1:0] bit_mask;
    logic             primed_q;
    logic             bit_hit;
    logic             frame_q;
    logic             stb_q;

    // Mode-dependent frame length, midpoint and bit-period mask.
    always_comb begin
        last_pos = POS_W'((BASE_TICKS >> speed_sel_i) - 1);
        half_pos = POS_W'((BASE_TICKS >> speed_sel_i) >> 1);
        bit_mask = POS_W'((STEP_BASE >> speed_sel_i) - 1);
        bit_hit  = tick_i && primed_q && ((pos_q & bit_mask) == '0);
    end

    // Tick position inside the frame.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            pos_q <= '0;
        end else if (tick_i) begin
            pos_q <= (pos_q == last_pos) ? '0 : pos_q + 1'b1;
        end
    end

    // Primed flag: set once the first full frame after a restart has elapsed.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            primed_q <= 1'b0;
        end else if (tick_i && (pos_q == last_pos)) begin
            primed_q <= 1'b1;
        end
    end

    // Output registers: strobe on bit boundaries, frame level updated with it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            stb_q   <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            stb_q <= bit_hit;
            if (bit_hit) begin
                frame_q <= (pos_q >= half_pos);
            end
        end
    end

    assign frame_o   = frame_q;
    assign bit_stb_o = stb_q;

endmodule

// File: rtl/aud_master_clkgen.sv
// Module: aud_master_clkgen (top)
// Audio master clock generator. A selector guard feeds a fractional
// pre-divider, which drives a frame sequencer. Every part runs in the single
// input clock domain.
// Assumes: the selector inputs are synchronous to clk_i.
module aud_master_clkgen #(
    parameter int BASE_TICKS     = 256,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] rate_sel_i,
    input  logic [1:0] speed_sel_i,
    output logic       frame_o,
    output logic       bit_stb_o,
    output logic       cfg_err_o
);

    logic [2:0] w_rate_q;
    logic [1:0] w_speed_q;
    logic       w_clear;
    logic       w_tick;

    aud_cfg_guard u_guard (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rate_sel_i  (rate_sel_i),
        .speed_sel_i (speed_sel_i),
        .rate_q_o    (w_rate_q),
        .speed_q_o   (w_speed_q),
        .clear_o     (w_clear),
        .cfg_err_o   (cfg_err_o)
    );

    aud_prediv #(.PHASE_W(2)) u_prediv (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (w_clear),
        .rate_sel_i (w_rate_q),
        .tick_o     (w_tick)
    );

    aud_frame_seq #(
        .BASE_TICKS     (BASE_TICKS),
        .BITS_PER_FRAME (BITS_PER_FRAME)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (w_clear),
        .tick_i      (w_tick),
        .speed_sel_i (w_speed_q),
        .frame_o     (frame_o),
        .bit_stb_o   (bit_stb_o)
    );

endmodule

// File: rtl/aud_master_clkgen_chk.sv
// Module: aud_master_clkgen_chk
// Assertion checker bound to the top. It observes ports plus the internal
// tick and clear nets that link the sub-blocks.
module aud_master_clkgen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] rate_sel_i,
    input logic [1:0] speed_sel_i,
    input logic       frame_o,
    input logic       bit_stb_o,
    input logic       cfg_err_o,
    input logic       tick,
    input logic       clear
);

    // R5: the frame clock rises only in a strobe cycle.
    a_r5_rise_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frame_o) |-> bit_stb_o);

    // R5: the frame clock falls only in a strobe cycle or after a restart.
    a_r5_fall_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(frame_o) |-> (bit_stb_o || $past(clear)));

    // R6: a selector change silences both outputs on the following cycle.
    a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rate_sel_i != $past(rate_sel_i)) || (speed_sel_i != $past(speed_sel_i)))
        |=> (!frame_o && !bit_stb_o));

    // R7: while the error flag is up, the outputs are idle.
    a_r7_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (!frame_o && !bit_stb_o));

    // R7: a reserved selector value raises the error flag one cycle later.
    a_r7_err_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rate_sel_i > 3'd4) || (speed_sel_i == 2'b11)) |=> cfg_err_o);

    // R3: a bit strobe is always preceded by a pre-divider tick.
    a_r3_strobe_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_stb_o |-> $past(tick));

    // R8: reset leaves every output low.
    a_r8_reset_idle: assert property (@(posedge clk_i)
        !rst_ni |=> (!frame_o && !bit_stb_o && !cfg_err_o));

endmodule

bind aud_master_clkgen aud_master_clkgen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rate_sel_i  (rate_sel_i),
    .speed_sel_i (speed_sel_i),
    .frame_o     (frame_o),
    .bit_stb_o   (bit_stb_o),
    .cfg_err_o   (cfg_err_o),
    .tick        (w_tick),
    .clear       (w_clear)
);

// File: tb/test_aud_master_clkgen.sv
// Directed bench for aud_master_clkgen: one task per scenario.
module test_aud_master_clkgen;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] rate_sel_i = 3'b000;
    logic [1:0] speed_sel_i = 2'b00;
    logic       frame_o;
    logic       bit_stb_o;
    logic       cfg_err_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk_i = ~clk_i;

    aud_master_clkgen i_aud_master_clkgen (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rate_sel_i  (rate_sel_i),
        .speed_sel_i (speed_sel_i),
        .frame_o     (frame_o),
        .bit_stb_o   (bit_stb_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected frame period in clock cycles, derived from R1 and R2.
    function automatic int exp_period(input logic [2:0] r, input logic [1:0] s);
        int base;
        base = 256 >> s;
        case (r)
            3'd0:    return base;
            3'd1:    return (base * 3) / 2;
            3'd2:    return base * 2;
            3'd3:    return base * 3;
            default: return base * 4;
        endcase
    endfunction

    // R8: outputs idle during and right after reset.
    task automatic t_reset();
        rst_ni = 1'b0;
        repeat (4) @(negedge clk_i);
        check(frame_o == 1'b0, "R8 frame in reset", frame_o, 0);
        check(bit_stb_o == 1'b0, "R8 strobe in reset", bit_stb_o, 0);
        check(cfg_err_o == 1'b0, "R8 error in reset", cfg_err_o, 0);
        rst_ni = 1'b1;
    endtask

    // R1 R2 R3 R4 R5: measure one full frame for a selector pair.
    task automatic t_frame(input logic [2:0] r, input logic [1:0] s);
        logic prev;
        bit   found;
        int   cnt, hi, sc, bad;
        rate_sel_i  = r;
        speed_sel_i = s;
        prev  = 1'b0;
        found = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            if (frame_o && !prev) begin
                found = 1'b1;
                break;
            end
            prev = frame_o;
        end
        check(found, "R2 frame start", int'(found), 1);
        cnt = 1;
        hi  = 1;
        sc  = int'(bit_stb_o);
        bad = bit_stb_o ? 0 : 1;
        prev = frame_o;
        found = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            if (frame_o != prev && !bit_stb_o) bad++;
            if (frame_o && !prev) begin
                found = 1'b1;
                break;
            end
            cnt++;
            hi += int'(frame_o);
            sc += int'(bit_stb_o);
            prev = frame_o;
        end
        check(found && cnt == exp_period(r, s), "R1 R2 frame period", cnt, exp_period(r, s));
        check(hi == exp_period(r, s) / 2, "R4 high time", hi, exp_period(r, s) / 2);
        check(sc == 64, "R3 strobes per frame", sc, 64);
        check(bad == 0, "R5 frame edges off strobe", bad, 0);
    endtask

    // R6: change selectors mid-run; outputs go quiet for a full new frame.
    task automatic t_restart(input logic [2:0] r, input logic [1:0] s);
        int quiet;
        repeat (37) @(negedge clk_i);
        rate_sel_i  = r;
        speed_sel_i = s;
        quiet = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            if (frame_o || bit_stb_o) break;
            quiet++;
        end
        check(quiet >= exp_period(r, s) - 3, "R6 quiet after change", quiet, exp_period(r, s) - 3);
    endtask

    // R7: reserved codes raise the error flag and keep outputs idle.
    task automatic t_reserved(input logic [2:0] r, input logic [1:0] s);
        int busy;
        rate_sel_i  = r;
        speed_sel_i = s;
        @(negedge clk_i);
        check(cfg_err_o == 1'b1, "R7 error flag", cfg_err_o, 1);
        busy = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_i);
            if (frame_o || bit_stb_o || !cfg_err_o) busy++;
        end
        check(busy == 0, "R7 idle while reserved", busy, 0);
        rate_sel_i  = 3'd0;
        speed_sel_i = 2'd2;
        @(negedge clk_i);
        check(cfg_err_o == 1'b0, "R7 error clears", cfg_err_o, 0);
    endtask

    // R9: ÷1.5 at quad speed gives two strobes in every three cycles.
    task automatic t_pattern();
        logic [29:0] seen;
        int bad;
        rate_sel_i  = 3'd1;
        speed_sel_i = 2'd2;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk_i);
            if (bit_stb_o) break;
        end
        seen = '0;
        for (int i = 0; i < 30; i++) begin
            seen[i] = bit_stb_o;
            @(negedge clk_i);
        end
        bad = 0;
        for (int i = 0; i < 28; i++) begin
            if (int'(seen[i]) + int'(seen[i+1]) + int'(seen[i+2]) != 2) bad++;
        end
        check(bad == 0, "R9 two-of-three pattern", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk_i);
        t_reset();
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 5; r++) begin
                t_frame(3'(r), 2'(s));
            end
        end
        t_restart(3'd2, 2'd1);
        t_restart(3'd1, 2'd0);
        t_reserved(3'd5, 2'd0);
        t_reserved(3'd0, 2'd3);
        t_reserved(3'd7, 2'd1);
        t_pattern();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule